// File: doc/BRIEF.md
# Mixed-width true dual-port RAM

A synchronous memory holding 16 Kbit of data and 2 Kbit of parity, shared by two ports that each run on their own clock with their own enable, write enable, synchronous output clear, address and data buses. Each port's shape is fixed by a parameter at one of six widths (1, 2, 4, 9, 18 or 36 bits). Two ports of different shape therefore act as a bus-width converter: a word written 36 bits wide can be read back nine bits at a time on the other port, or the reverse.

The three wide shapes split into eight data bits plus one parity bit per byte lane, carried on a separate parity bus. The block only stores those bits; it never computes or checks them. The three narrow shapes reach the data bits alone. Every port behaves like a register: inputs are taken on the rising clock edge and the read result appears as a result of that same edge. During a write, the port shows the data it is writing.

If both ports write the same bit on edges that coincide, the stored value of that bit is undefined. A port that reads a bit which the other port writes on a coincident edge may see either the old or the new value. Users keep the two ports apart in time for shared bits.

Top module: `mw_dpram`

## Requirements
- R1: While a port's rst_n is low at its rising clock edge, that port's data and parity outputs become 0 and nothing is written. All stored bits start at 0.
- R2: A read (en=1, we=0, srst=0) makes the outputs show the stored content of the address sampled at that same edge, with no further pipeline stage.
- R3: With en=0 the port's outputs hold their value and nothing is written, even with we=1.
- R4: With en=1 and srst=1 the outputs become 0 at the edge. srst alone never changes stored bits, and a write requested in the same cycle is still stored.
- R5: On a write (en=1, we=1, srst=0) the outputs show the data and parity being written (write-first).
- R6: Each WIDTH value gives D data bits and P parity bits per access: 1→1/0, 2→2/0, 4→4/0, 9→8/1, 18→16/2, 36→32/4. Storage is DEPTH_WORDS words of 32 data plus 4 parity bits. A port address is {word index, sub index}, where the sub index holds log2(32/D) low bits. Sub index k covers data bits [k*D +: D] and parity bits [k*P +: P] of the word.
- R7: For widths 1, 2 and 4 the parity input is 1 bit wide and ignored, and the parity output is always 0.
- R8: Parity bits are stored and returned with the same timing as data bits, and may be written at one parity-capable width and read at another.
- R9: A write on one port is visible to a read on the other port at any edge of that port strictly later than the write edge.
- R10: A write changes only its own D data and P parity bits. All other bits of the word are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock, rising edge active |
| rst_a_n | input | 1 | Port A synchronous active-low reset of the output register |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| srst_a | input | 1 | Port A synchronous output clear |
| addr_a | input | AW_A (9 by default) | Port A address {word index, sub index} |
| din_a | input | DW_A (32 by default) | Port A write data |
| dinp_a | input | PW_A (4 by default) | Port A write parity |
| dout_a | output | DW_A | Port A read data |
| doutp_a | output | PW_A | Port A read parity |
| clk_b | input | 1 | Port B clock, rising edge active |
| rst_b_n | input | 1 | Port B synchronous active-low reset of the output register |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| srst_b | input | 1 | Port B synchronous output clear |
| addr_b | input | AW_B (11 by default) | Port B address {word index, sub index} |
| din_b | input | DW_B (8 by default) | Port B write data |
| dinp_b | input | PW_B (1 by default) | Port B write parity |
| dout_b | output | DW_B | Port B read data |
| doutp_b | output | PW_B | Port B read parity |

## Verification
Every result of a port (read data, write-first echo, srst or reset clear) is due on the first rising edge of that port's own clock after the inputs are presented. The bench therefore drives each operation at a falling edge, lets exactly one rising edge pass, samples at the following falling edge and drops the enable so that the output holds. A cross-port check starts its read only after the writing port's task has returned, so the read edge lies strictly after the write edge on unrelated clocks. Expected values come from a bench-side bit array of 32 data plus 4 parity bits per word that is indexed with the address split from R6.

// File: rtl/mw_dpram_pkg.sv
// Package: shape arithmetic shared by the mixed-width dual-port RAM.
// Assumes WIDTH is one of 1, 2, 4, 9, 18, 36. Any other value maps to a
// 1-bit shape.
package mw_dpram_pkg;

    localparam int WORD_DATA_W = 32;
    localparam int WORD_PAR_W  = 4;
    localparam int WORD_W      = WORD_DATA_W + WORD_PAR_W;

    // Data bits carried by one access of a port of this width.
    function automatic int data_bits(input int width);
        case (width)
            2:       return 2;
            4:       return 4;
            9:       return 8;
            18:      return 16;
            36:      return 32;
            default: return 1;
        endcase
    endfunction

    // Parity bits carried by one access (zero for the narrow shapes).
    function automatic int par_bits(input int width);
        case (width)
            9:       return 1;
            18:      return 2;
            36:      return 4;
            default: return 0;
        endcase
    endfunction

    // Width of the parity port: a narrow shape still gets a 1-bit stub.
    function automatic int par_port_bits(input int width);
        return (par_bits(width) > 0) ? par_bits(width) : 1;
    endfunction

    // Address bits that select a sub-word inside one storage word.
    function automatic int sub_bits(input int width);
        return $clog2(WORD_DATA_W / data_bits(width));
    endfunction

endpackage

// File: rtl/mw_lane_map.sv
// Lane map: turns a port address and write data into a storage-word index,
// a 36-bit write mask and an aligned write vector, and extracts the port's
// read data from a full storage word.
// Assumes: word layout is data[31:0], parity[35:32]; sub-word k sits at
// data bits k*D and parity bits k*P. Purely combinational.
module mw_lane_map
    import mw_dpram_pkg::*;
#(
    parameter int WIDTH = 36,
    parameter int IDX_W = 9,
    localparam int DB = data_bits(WIDTH),
    localparam int PB = par_bits(WIDTH),
    localparam int PW = par_port_bits(WIDTH),
    localparam int SB = sub_bits(WIDTH),
    localparam int AW = IDX_W + SB
) (
    input  logic [AW-1:0]     addr,
    input  logic [DB-1:0]     wdata,
    input  logic [PW-1:0]     wpar,
    input  logic [WORD_W-1:0] word,
    output logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] wr_mask,
    output logic [WORD_W-1:0] wr_vec,
    output logic [DB-1:0]     rdata,
    output logic [PW-1:0]     rpar
);

    localparam logic [WORD_DATA_W-1:0] D_ONES =
        (DB >= WORD_DATA_W) ? {WORD_DATA_W{1'b1}} : ((32'd1 << DB) - 32'd1);
    localparam logic [WORD_PAR_W-1:0] P_ONES = 4'((1 << PB) - 1);

    logic [4:0]            sub;
    logic [WORD_PAR_W-1:0] par_in;
    int                    d_shift;
    int                    p_shift;

    // Split the address into word index and sub-word index.
    generate
        if (SB > 0) begin : g_sub
            assign idx = addr[AW-1:SB];
            assign sub = 5'(addr[SB-1:0]);
        end else begin : g_full
            assign idx = addr;
            assign sub = 5'd0;
        end
    endgenerate

    // Bit offsets of the addressed lanes inside the storage word.
    assign d_shift = int'(sub) * DB;
    assign p_shift = int'(sub) * PB;
    assign par_in  = (PB > 0) ? 4'(wpar) : 4'd0;

    // Build the write mask and the aligned write vector.
    always_comb begin
        wr_mask = {P_ONES << p_shift, D_ONES << d_shift};
        wr_vec  = {(par_in & P_ONES) << p_shift, 32'(wdata) << d_shift};
    end

    // Pull the addressed lanes out of a full storage word.
    always_comb begin
        rdata = DB'(word[WORD_DATA_W-1:0] >> d_shift);
        rpar  = (PB > 0) ? PW'(word[WORD_W-1:WORD_DATA_W] >> p_shift) : '0;
    end

endmodule

// File: rtl/mw_xor_bank.sv
// XOR bank: one of two storage banks, written only from its own port's
// clock. A stored word holds (new bits XOR peer bank word), so the logical
// content is bank_a ^ bank_b and no bit has two writers.
// Assumes: peer_word is the other bank's word at wr_idx; bits outside
// wr_mask keep their stored value. Power-up content is zero.
module mw_xor_bank
    import mw_dpram_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_mask,
    input  logic [WORD_W-1:0] wr_vec,
    input  logic [WORD_W-1:0] peer_word,
    input  logic [IDX_W-1:0]  rd_idx_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic [WORD_W-1:0] rd_word_a,
    output logic [WORD_W-1:0] rd_word_b
);

    logic [WORD_W-1:0] mem [DEPTH];

    // Zero power-up content so that both banks XOR to a known value.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = '0;
        end
    end

    // Masked write that encodes the new bits against the peer bank.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= (mem[wr_idx] & ~wr_mask) | ((wr_vec ^ peer_word) & wr_mask);
        end
    end

    // Asynchronous word reads for both ports' address paths.
    assign rd_word_a = mem[rd_idx_a];
    assign rd_word_b = mem[rd_idx_b];

endmodule

// File: rtl/mw_out_reg.sv
// Output register of one port: synchronous active-low reset, enable hold,
// synchronous clear, write-first echo, otherwise the read lanes.
// Assumes HAS_PAR is 0 for narrow shapes; their parity output stays zero.
module mw_out_reg #(
    parameter int DB      = 32,
    parameter int PW      = 4,
    parameter bit HAS_PAR = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          srst,
    input  logic          we,
    input  logic [DB-1:0] wdata,
    input  logic [PW-1:0] wpar,
    input  logic [DB-1:0] rdata,
    input  logic [PW-1:0] rpar,
    output logic [DB-1:0] dout,
    output logic [PW-1:0] doutp
);

    // Register the port result selected by reset, clear, write or read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= '0;
            doutp <= '0;
        end else if (en) begin
            if (srst) begin
                dout  <= '0;
                doutp <= '0;
            end else if (we) begin
                dout  <= wdata;
                doutp <= HAS_PAR ? wpar : '0;
            end else begin
                dout  <= rdata;
                doutp <= HAS_PAR ? rpar : '0;
            end
        end
    end

endmodule

// File: rtl/mw_dpram.sv
// Mixed-width true dual-port RAM: DEPTH_WORDS words of 32 data + 4 parity
// bits, two ports on independent clocks with parameter-chosen shapes.
// Assumes: WIDTH_A/WIDTH_B in {1,2,4,9,18,36}; DEPTH_WORDS a power of two;
// same-bit writes from both ports on coincident edges leave that bit undefined.
module mw_dpram
    import mw_dpram_pkg::*;
#(
    parameter int WIDTH_A     = 36,
    parameter int WIDTH_B     = 9,
    parameter int DEPTH_WORDS = 512,
    localparam int IDX_W = $clog2(DEPTH_WORDS),
    localparam int DW_A  = data_bits(WIDTH_A),
    localparam int PW_A  = par_port_bits(WIDTH_A),
    localparam int AW_A  = IDX_W + sub_bits(WIDTH_A),
    localparam int DW_B  = data_bits(WIDTH_B),
    localparam int PW_B  = par_port_bits(WIDTH_B),
    localparam int AW_B  = IDX_W + sub_bits(WIDTH_B)
) (
    input  logic            clk_a,
    input  logic            rst_a_n,
    input  logic            en_a,
    input  logic            we_a,
    input  logic            srst_a,
    input  logic [AW_A-1:0] addr_a,
    input  logic [DW_A-1:0] din_a,
    input  logic [PW_A-1:0] dinp_a,
    output logic [DW_A-1:0] dout_a,
    output logic [PW_A-1:0] doutp_a,
    input  logic            clk_b,
    input  logic            rst_b_n,
    input  logic            en_b,
    input  logic            we_b,
    input  logic            srst_b,
    input  logic [AW_B-1:0] addr_b,
    input  logic [DW_B-1:0] din_b,
    input  logic [PW_B-1:0] dinp_b,
    output logic [DW_B-1:0] dout_b,
    output logic [PW_B-1:0] doutp_b
);

    localparam bit PAR_A = par_bits(WIDTH_A) > 0;
    localparam bit PAR_B = par_bits(WIDTH_B) > 0;

    logic [IDX_W-1:0]  idx_a, idx_b;
    logic [WORD_W-1:0] mask_a, mask_b, vec_a, vec_b;
    logic [WORD_W-1:0] ka_at_a, ka_at_b, kb_at_a, kb_at_b;
    logic [WORD_W-1:0] word_a, word_b;
    logic [DW_A-1:0]   rdata_a;
    logic [PW_A-1:0]   rpar_a;
    logic [DW_B-1:0]   rdata_b;
    logic [PW_B-1:0]   rpar_b;
    logic              wr_a, wr_b;

    // Logical word seen by each port: XOR of the two banks.
    assign word_a = ka_at_a ^ kb_at_a;
    assign word_b = ka_at_b ^ kb_at_b;

    // A write needs an enabled, out-of-reset port with we set.
    assign wr_a = rst_a_n & en_a & we_a;
    assign wr_b = rst_b_n & en_b & we_b;

    mw_lane_map #(.WIDTH(WIDTH_A), .IDX_W(IDX_W)) u_map_a (
        .addr(addr_a), .wdata(din_a), .wpar(dinp_a), .word(word_a),
        .idx(idx_a), .wr_mask(mask_a), .wr_vec(vec_a),
        .rdata(rdata_a), .rpar(rpar_a)
    );

    mw_lane_map #(.WIDTH(WIDTH_B), .IDX_W(IDX_W)) u_map_b (
        .addr(addr_b), .wdata(din_b), .wpar(dinp_b), .word(word_b),
        .idx(idx_b), .wr_mask(mask_b), .wr_vec(vec_b),
        .rdata(rdata_b), .rpar(rpar_b)
    );

    mw_xor_bank #(.DEPTH(DEPTH_WORDS)) u_bank_a (
        .clk(clk_a), .wr_en(wr_a), .wr_idx(idx_a),
        .wr_mask(mask_a), .wr_vec(vec_a), .peer_word(kb_at_a),
        .rd_idx_a(idx_a), .rd_idx_b(idx_b),
        .rd_word_a(ka_at_a), .rd_word_b(ka_at_b)
    );

    mw_xor_bank #(.DEPTH(DEPTH_WORDS)) u_bank_b (
        .clk(clk_b), .wr_en(wr_b), .wr_idx(idx_b),
        .wr_mask(mask_b), .wr_vec(vec_b), .peer_word(ka_at_b),
        .rd_idx_a(idx_a), .rd_idx_b(idx_b),
        .rd_word_a(kb_at_a), .rd_word_b(kb_at_b)
    );

    mw_out_reg #(.DB(DW_A), .PW(PW_A), .HAS_PAR(PAR_A)) u_out_a (
        .clk(clk_a), .rst_n(rst_a_n), .en(en_a), .srst(srst_a), .we(we_a),
        .wdata(din_a), .wpar(dinp_a), .rdata(rdata_a), .rpar(rpar_a),
        .dout(dout_a), .doutp(doutp_a)
    );

    mw_out_reg #(.DB(DW_B), .PW(PW_B), .HAS_PAR(PAR_B)) u_out_b (
        .clk(clk_b), .rst_n(rst_b_n), .en(en_b), .srst(srst_b), .we(we_b),
        .wdata(din_b), .wpar(dinp_b), .rdata(rdata_b), .rpar(rpar_b),
        .dout(dout_b), .doutp(doutp_b)
    );

endmodule

// File: rtl/mw_dpram_chk.sv
// Checker bound to mw_dpram: per-port output register behaviour over time.
// Assumes the same parameters as the bound instance.
module mw_dpram_chk
    import mw_dpram_pkg::*;
#(
    parameter int WIDTH_A     = 36,
    parameter int WIDTH_B     = 9,
    parameter int DEPTH_WORDS = 512,
    localparam int DW_A  = data_bits(WIDTH_A),
    localparam int PW_A  = par_port_bits(WIDTH_A),
    localparam int DW_B  = data_bits(WIDTH_B),
    localparam int PW_B  = par_port_bits(WIDTH_B)
) (
    input logic            clk_a,
    input logic            rst_a_n,
    input logic            en_a,
    input logic            we_a,
    input logic            srst_a,
    input logic [DW_A-1:0] din_a,
    input logic [PW_A-1:0] dinp_a,
    input logic [DW_A-1:0] dout_a,
    input logic [PW_A-1:0] doutp_a,
    input logic            clk_b,
    input logic            rst_b_n,
    input logic            en_b,
    input logic            we_b,
    input logic            srst_b,
    input logic [DW_B-1:0] din_b,
    input logic [PW_B-1:0] dinp_b,
    input logic [DW_B-1:0] dout_b,
    input logic [PW_B-1:0] doutp_b
);

    localparam bit PAR_A = par_bits(WIDTH_A) > 0;
    localparam bit PAR_B = par_bits(WIDTH_B) > 0;

    AST_IDLE_HOLD_A: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        !en_a |=> $stable(dout_a) && $stable(doutp_a)); // R3
    AST_IDLE_HOLD_B: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        !en_b |=> $stable(dout_b) && $stable(doutp_b)); // R3
    AST_CLEAR_ZERO_A: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        en_a && srst_a |=> dout_a == '0 && doutp_a == '0); // R4
    AST_CLEAR_ZERO_B: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        en_b && srst_b |=> dout_b == '0 && doutp_b == '0); // R4
    AST_WRITE_ECHO_A: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        en_a && we_a && !srst_a |=> dout_a == $past(din_a)
            && doutp_a == (PAR_A ? $past(dinp_a) : '0)); // R5
    AST_WRITE_ECHO_B: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        en_b && we_b && !srst_b |=> dout_b == $past(din_b)
            && doutp_b == (PAR_B ? $past(dinp_b) : '0)); // R5

endmodule

bind mw_dpram mw_dpram_chk #(
    .WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B), .DEPTH_WORDS(DEPTH_WORDS)
) u_chk (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .en_a(en_a), .we_a(we_a), .srst_a(srst_a),
    .din_a(din_a), .dinp_a(dinp_a), .dout_a(dout_a), .doutp_a(doutp_a),
    .clk_b(clk_b), .rst_b_n(rst_b_n), .en_b(en_b), .we_b(we_b), .srst_b(srst_b),
    .din_b(din_b), .dinp_b(dinp_b), .dout_b(dout_b), .doutp_b(doutp_b)
);

// File: tb/mw_dpram_test.sv
// Directed bench: uut is 36-bit A / 9-bit B; uut_n is 2-bit A / 18-bit B.
module mw_dpram_test;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic rst_a_n = 1'b0;
    logic rst_b_n = 1'b0;
    always #5 clk_a = ~clk_a;
    always #7 clk_b = ~clk_b;

    // uut: port A 36 bits (addr 9), port B 9 bits (addr 11)
    logic        en_a = 0, we_a = 0, srst_a = 0;
    logic [8:0]  addr_a = '0;
    logic [31:0] din_a = '0;
    logic [3:0]  dinp_a = '0;
    logic [31:0] dout_a;
    logic [3:0]  doutp_a;
    logic        en_b = 0, we_b = 0, srst_b = 0;
    logic [10:0] addr_b = '0;
    logic [7:0]  din_b = '0;
    logic [0:0]  dinp_b = '0;
    logic [7:0]  dout_b;
    logic [0:0]  doutp_b;

    // uut_n: port A 2 bits (addr 13), port B 18 bits (addr 10)
    logic        n_en_a = 0, n_we_a = 0;
    logic [12:0] n_addr_a = '0;
    logic [1:0]  n_din_a = '0;
    logic [0:0]  n_dinp_a = '0;
    logic [1:0]  n_dout_a;
    logic [0:0]  n_doutp_a;
    logic        n_en_b = 0, n_we_b = 0;
    logic [9:0]  n_addr_b = '0;
    logic [15:0] n_din_b = '0;
    logic [1:0]  n_dinp_b = '0;
    logic [15:0] n_dout_b;
    logic [1:0]  n_doutp_b;

    mw_dpram uut (
        .clk_a(clk_a), .rst_a_n(rst_a_n), .en_a(en_a), .we_a(we_a), .srst_a(srst_a),
        .addr_a(addr_a), .din_a(din_a), .dinp_a(dinp_a), .dout_a(dout_a), .doutp_a(doutp_a),
        .clk_b(clk_b), .rst_b_n(rst_b_n), .en_b(en_b), .we_b(we_b), .srst_b(srst_b),
        .addr_b(addr_b), .din_b(din_b), .dinp_b(dinp_b), .dout_b(dout_b), .doutp_b(doutp_b)
    );

    mw_dpram #(.WIDTH_A(2), .WIDTH_B(18)) uut_n (
        .clk_a(clk_a), .rst_a_n(rst_a_n), .en_a(n_en_a), .we_a(n_we_a), .srst_a(1'b0),
        .addr_a(n_addr_a), .din_a(n_din_a), .dinp_a(n_dinp_a), .dout_a(n_dout_a),
        .doutp_a(n_doutp_a),
        .clk_b(clk_b), .rst_b_n(rst_b_n), .en_b(n_en_b), .we_b(n_we_b), .srst_b(1'b0),
        .addr_b(n_addr_b), .din_b(n_din_b), .dinp_b(n_dinp_b), .dout_b(n_dout_b),
        .doutp_b(n_doutp_b)
    );

    // Reference model of uut: 32 data + 4 parity bits per word.
    logic [31:0] ref_d [512];
    logic [3:0]  ref_p [512];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One port A operation; result sampled at the following falling edge.
    task automatic op_a(input logic en, input logic we, input logic sr,
                        input logic [8:0] a, input logic [31:0] d, input logic [3:0] p);
        @(negedge clk_a);
        en_a = en; we_a = we; srst_a = sr; addr_a = a; din_a = d; dinp_a = p;
        @(negedge clk_a);
        en_a = 0; we_a = 0; srst_a = 0;
        if (en && we && rst_a_n) begin
            ref_d[a] = d;
            ref_p[a] = p;
        end
    endtask

    task automatic op_b(input logic en, input logic we, input logic sr,
                        input logic [10:0] a, input logic [7:0] d, input logic p);
        @(negedge clk_b);
        en_b = en; we_b = we; srst_b = sr; addr_b = a; din_b = d; dinp_b = p;
        @(negedge clk_b);
        en_b = 0; we_b = 0; srst_b = 0;
        if (en && we && rst_b_n) begin
            ref_d[a[10:2]][int'(a[1:0])*8 +: 8] = d;
            ref_p[a[10:2]][a[1:0]] = p;
        end
    endtask

    function automatic logic [7:0] exp_bd(input logic [10:0] a);
        return ref_d[a[10:2]][int'(a[1:0])*8 +: 8];
    endfunction

    function automatic logic exp_bp(input logic [10:0] a);
        return ref_p[a[10:2]][a[1:0]];
    endfunction

    task automatic t_reset;
        op_a(1, 1, 0, 9'd5, 32'hDEAD_BEEF, 4'hF);
        chk("R1 reset clears A data", dout_a, 0);
        chk("R1 reset clears A parity", doutp_a, 0);
        op_b(1, 1, 0, 11'd20, 8'h77, 1'b1);
        chk("R1 reset clears B data", dout_b, 0);
        @(negedge clk_a); rst_a_n = 1;
        @(negedge clk_b); rst_b_n = 1;
        op_a(1, 0, 0, 9'd5, 32'h0, 4'h0);
        chk("R1 no write during reset, zero start", {doutp_a, dout_a}, 0);
    endtask

    task automatic t_wide_rw;
        op_a(1, 1, 0, 9'd10, 32'h1234_5678, 4'hA);
        chk("R5 write-first data A", dout_a, 32'h1234_5678);
        chk("R5 write-first parity A", doutp_a, 4'hA);
        op_a(1, 1, 0, 9'd11, 32'hCAFE_F00D, 4'h5);
        op_a(1, 0, 0, 9'd10, 32'h0, 4'h0);
        chk("R2 read data A", dout_a, 32'h1234_5678);
        chk("R8 read parity A", doutp_a, 4'hA);
        op_a(1, 0, 0, 9'd11, 32'h0, 4'h0);
        chk("R2 read second word A", {doutp_a, dout_a}, {4'h5, 32'hCAFE_F00D});
    endtask

    task automatic t_narrow_read;
        for (int k = 0; k < 4; k++) begin
            logic [10:0] a;
            a = {9'd10, 2'(k)};
            op_b(1, 0, 0, a, 8'h0, 1'b0);
            chk("R6 sub-word data B", dout_b, exp_bd(a));
            chk("R8 parity across widths B", doutp_b, exp_bp(a));
        end
    endtask

    task automatic t_narrow_write;
        op_b(1, 1, 0, {9'd10, 2'd2}, 8'h9C, 1'b1);
        chk("R5 write-first data B", {doutp_b, dout_b}, {1'b1, 8'h9C});
        op_a(1, 0, 0, 9'd10, 32'h0, 4'h0);
        chk("R10 R9 partial write data seen by A", dout_a, 32'h129C_5678);
        chk("R10 partial write parity seen by A", doutp_a, 4'hE);
    endtask

    task automatic t_enable_low;
        op_a(1, 0, 0, 9'd11, 32'h0, 4'h0);
        op_a(0, 1, 0, 9'd11, 32'h0BAD_0BAD, 4'h3);
        chk("R3 output holds with enable low", dout_a, 32'hCAFE_F00D);
        op_b(0, 1, 0, {9'd11, 2'd0}, 8'h11, 1'b0);
        op_a(1, 0, 0, 9'd11, 32'h0, 4'h0);
        chk("R3 no write with enable low", {doutp_a, dout_a}, {4'h5, 32'hCAFE_F00D});
    endtask

    task automatic t_srst;
        op_a(1, 0, 1, 9'd10, 32'h0, 4'h0);
        chk("R4 srst clears output A", {doutp_a, dout_a}, 0);
        op_a(1, 0, 0, 9'd10, 32'h0, 4'h0);
        chk("R4 srst leaves memory", dout_a, ref_d[10]);
        op_b(1, 1, 1, {9'd12, 2'd1}, 8'h5A, 1'b1);
        chk("R4 srst with write clears output B", {doutp_b, dout_b}, 0);
        op_a(1, 0, 0, 9'd12, 32'h0, 4'h0);
        chk("R4 write under srst stored", {doutp_a, dout_a}, {ref_p[12], ref_d[12]});
    endtask

    task automatic t_narrow_parity;
        @(negedge clk_b);
        n_en_b = 1; n_we_b = 1; n_addr_b = {9'd3, 1'b0}; n_din_b = 16'hA5C3; n_dinp_b = 2'b10;
        @(negedge clk_b); n_en_b = 0; n_we_b = 0;
        @(negedge clk_a);
        n_en_a = 1; n_addr_a = {9'd3, 4'd3};
        @(negedge clk_a); n_en_a = 0;
        chk("R6 2-bit lane 3 of 18-bit write", n_dout_a, 2'b11);
        chk("R7 narrow parity output zero", n_doutp_a, 0);
        @(negedge clk_a);
        n_en_a = 1; n_we_a = 1; n_addr_a = {9'd3, 4'd0}; n_din_a = 2'b10; n_dinp_a = 1'b1;
        @(negedge clk_a); n_en_a = 0; n_we_a = 0;
        chk("R7 narrow write echo parity zero", n_doutp_a, 0);
        @(negedge clk_b);
        n_en_b = 1; n_addr_b = {9'd3, 1'b0};
        @(negedge clk_b); n_en_b = 0;
        chk("R10 narrow write merges data", n_dout_b, 16'hA5C2);
        chk("R7 narrow parity input ignored", n_doutp_b, 2'b10);
    endtask

    task automatic t_mixed_traffic;
        logic [31:0] lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 80; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[0]) begin
                logic [8:0] a;
                logic [31:0] e_d;
                logic [3:0] e_p;
                a = {5'd0, lfsr[12:9]};
                e_d = lfsr[1] ? lfsr : ref_d[a];
                e_p = lfsr[1] ? lfsr[27:24] : ref_p[a];
                op_a(1, lfsr[1], 0, a, lfsr, lfsr[27:24]);
                chk("R9 mixed traffic A", {doutp_a, dout_a}, {e_p, e_d});
            end else begin
                logic [10:0] a;
                logic [7:0] e_d;
                logic e_p;
                a = {5'd0, lfsr[17:12]};
                e_d = lfsr[1] ? lfsr[23:16] : exp_bd(a);
                e_p = lfsr[1] ? lfsr[5] : exp_bp(a);
                op_b(1, lfsr[1], 0, a, lfsr[23:16], lfsr[5]);
                chk("R9 mixed traffic B", {doutp_b, dout_b}, {e_p, e_d});
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 512; i++) begin
            ref_d[i] = '0;
            ref_p[i] = '0;
        end
        t_reset();
        t_wide_rw();
        t_narrow_read();
        t_narrow_write();
        t_enable_low();
        t_srst();
        t_narrow_parity();
        t_mixed_traffic();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk_a);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule